// File: doc/BRIEF.md
# Priority Interrupt Arbiter

This block decides which of a set of maskable interrupt sources, if any, the processor should take next. Every source owns a stored request bit and a 3-bit priority level. The first `NUM_EXT` sources are external pins. Each pin can be set to edge or level sensing, with a polarity choice. The remaining sources are internal and raise their request through a one-cycle event pulse. Two special requests, a reset request and a watchdog request, sit above all maskable sources in a fixed order.

When the processor fetches an opcode, the block takes a snapshot of the requests and levels. It then waits a programmable number of clocks before it decides. A chain of comparisons picks the winning source. The winner is taken only if its level is above the current processor level and interrupts are not disabled. On acceptance the block sends a one-cycle handshake pulse with the source index and the new processor level, and it clears the winner's request bit. Vector lookup and stack handling belong to the CPU.

Top module: `prio_arb`

## Requirements
- R1: After reset, `irq_take` is 0, every bit of `req_pend` is 0 and `wdt_pend` is 0.
- R2: An external source in edge mode (`ext_lvl`=0) sets its request bit on a falling pin edge when `ext_pol`=0 and on a rising edge when `ext_pol`=1. The opposite edge leaves the bit unchanged. External sources occupy indices 0 to NUM_EXT-1. Internal event bit k maps to source NUM_EXT+k.
- R3: An external source in level mode (`ext_lvl`=1) requests while its pin is high with `ext_pol`=0, or low with `ext_pol`=1. Its stored request bit plays no part in arbitration.
- R4: A `sw_clr` bit clears the matching request bit. If a new hardware event for that source arrives in the same cycle, the bit stays set.
- R5: Among the snapshot's requesting sources, the highest level wins. On a tie the lowest index wins. A level of 0 never wins.
- R6: A maskable winner is taken only when its level is strictly greater than `cpu_ipl` and `cpu_idis` is 0. Both values are sampled at the decision edge. Otherwise nothing is taken and the request bits keep their values.
- R7: On acceptance, `irq_take` is high for exactly one cycle, `irq_id` gives the source index, `irq_ipl` gives the winner's level, and the winner's request bit reads 0 from that cycle on.
- R8: A pending reset request beats a pending watchdog request, and the watchdog beats every maskable source. Both ignore `cpu_idis` and `cpu_ipl`. Reset is reported as `irq_id`=NUM_SRC+1 with `irq_ipl`=0. The watchdog is reported as `irq_id`=NUM_SRC with `irq_ipl`=7.
- R9: The watchdog and reset pending flags clear only when their own request is taken. `sw_clr` has no effect on them.
- R10: A `fetch` pulse while idle captures the requests and levels. The outcome appears on `irq_take` D rising edges after the fetch edge. D is 7 for `dly_sel`=00, 4 for 01, 2 for 10, and 7 for the reserved 11. Fetches during the wait and requests arriving after the fetch edge do not affect that decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch | input | 1 | Opcode fetch strobe; starts a snapshot when idle |
| dly_sel | input | 2 | Decision delay code |
| cpu_ipl | input | 3 | Current processor priority level |
| cpu_idis | input | 1 | Processor interrupt-disable flag |
| src_lvl | input | NUM_SRC*3 | Per-source priority levels, source i in bits [3i+2:3i] |
| hw_evt | input | NUM_SRC-NUM_EXT | Internal source event pulses |
| ext_pin | input | NUM_EXT | External interrupt pins |
| ext_pol | input | NUM_EXT | Polarity select per external source |
| ext_lvl | input | NUM_EXT | 1 = level sense, 0 = edge sense |
| sw_clr | input | NUM_SRC | Software clear of request bits |
| rst_evt | input | 1 | Reset request pulse |
| wdt_evt | input | 1 | Watchdog request pulse |
| irq_take | output | 1 | One-cycle acceptance handshake |
| irq_id | output | $clog2(NUM_SRC+2) | Index of the accepted request |
| irq_ipl | output | 3 | New processor level on acceptance |
| req_pend | output | NUM_SRC | Stored request bits |
| wdt_pend | output | 1 | Watchdog request pending |

## Verification
The bench sweeps every combination of four source levels against a rotating processor level, disable flag and delay code. This exposes a chain that breaks ties toward the wrong end, compares with greater-or-equal instead of strictly greater, or lets a level-0 source win. Directed sequences cover the remaining cases:
- each edge polarity, where a swapped polarity would latch on the wrong transition;
- a stale stored bit under level sensing, which a wrong design would grant;
- a software clear colliding with a fresh event, which a wrong design would lose;
- reset and watchdog arriving together while interrupts are disabled, which a wrong design would order incorrectly or mask.

A request that lands during the decision wait, and a second fetch during that wait, would each cause a grant in a design that samples continuously or restarts its timer.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;
  localparam int unsigned LVL_W = 3;
  localparam int unsigned CNT_W = 3;

  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LVL_AFTER_RST = '0;
  localparam lvl_t LVL_AFTER_WDT = '1;

  // decision delay in clocks for each select code; reserved code acts as the slowest
  function automatic logic [CNT_W-1:0] wait_cycles(input logic [1:0] sel);
    case (sel)
      2'b01:   return CNT_W'(4);
      2'b10:   return CNT_W'(2);
      default: return CNT_W'(7);
    endcase
  endfunction

  // a candidate displaces the running best only when strictly higher
  function automatic logic outranks(input lvl_t cand, input lvl_t best);
    return cand > best;
  endfunction
endpackage

// File: rtl/prio_arb_req.sv
module prio_arb_req
  import prio_arb_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned NUM_EXT = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SRC-NUM_EXT-1:0] hw_evt,
  input  logic [NUM_EXT-1:0]         ext_pin,
  input  logic [NUM_EXT-1:0]         ext_pol,
  input  logic [NUM_EXT-1:0]         ext_lvl,
  input  logic [NUM_SRC-1:0]         sw_clr,
  input  logic [NUM_SRC-1:0]         acc_clr,
  output logic [NUM_SRC-1:0]         req_eff,
  output logic [NUM_SRC-1:0]         req_q
);
  logic [NUM_SRC-1:0] set_w;
  logic               armed;

  // edge detectors stay blind until the first pin sample after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (i < NUM_EXT) begin : g_ext
      logic prev;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= ext_pin[i];
      end
      assign set_w[i] = armed & ~ext_lvl[i] &
                        (ext_pol[i] ? (~prev & ext_pin[i]) : (prev & ~ext_pin[i]));
      assign req_eff[i] = ext_lvl[i] ? (ext_pin[i] ^ ext_pol[i]) : req_q[i];
    end else begin : g_int
      assign set_w[i]   = hw_evt[i-NUM_EXT];
      assign req_eff[i] = req_q[i];
    end

    // a fresh hardware event outranks any clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q[i] <= 1'b0;
      else        req_q[i] <= set_w[i] | (req_q[i] & ~(sw_clr[i] | acc_clr[i]));
    end
  end

  assert_evt_beats_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_w != '0) |=> ((req_q & $past(set_w)) == $past(set_w)));
endmodule

// File: rtl/prio_arb_chain.sv
module prio_arb_chain
  import prio_arb_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned IDX_W   = 4
) (
  input  logic [NUM_SRC-1:0] req,
  input  lvl_t [NUM_SRC-1:0] lvl,
  output logic               win_vld,
  output logic [IDX_W-1:0]   win_idx,
  output lvl_t               win_lvl
);
  lvl_t             st_lvl [NUM_SRC+1];
  logic [IDX_W-1:0] st_idx [NUM_SRC+1];
  logic             st_vld [NUM_SRC+1];

  assign st_lvl[0] = '0;
  assign st_idx[0] = '0;
  assign st_vld[0] = 1'b0;

  // stage i lets source i take over only on a strictly higher level
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_stage
    logic take;
    assign take        = req[i] & outranks(lvl[i], st_lvl[i]);
    assign st_lvl[i+1] = take ? lvl[i] : st_lvl[i];
    assign st_idx[i+1] = take ? IDX_W'(i) : st_idx[i];
    assign st_vld[i+1] = take | st_vld[i];
  end

  assign win_vld = st_vld[NUM_SRC];
  assign win_idx = st_idx[NUM_SRC];
  assign win_lvl = st_lvl[NUM_SRC];
endmodule

// File: rtl/prio_arb.sv
module prio_arb
  import prio_arb_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned NUM_EXT = 2,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC + 2)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fetch,
  input  logic [1:0]                 dly_sel,
  input  logic [LVL_W-1:0]           cpu_ipl,
  input  logic                       cpu_idis,
  input  logic [NUM_SRC*LVL_W-1:0]   src_lvl,
  input  logic [NUM_SRC-NUM_EXT-1:0] hw_evt,
  input  logic [NUM_EXT-1:0]         ext_pin,
  input  logic [NUM_EXT-1:0]         ext_pol,
  input  logic [NUM_EXT-1:0]         ext_lvl,
  input  logic [NUM_SRC-1:0]         sw_clr,
  input  logic                       rst_evt,
  input  logic                       wdt_evt,
  output logic                       irq_take,
  output logic [IDX_W-1:0]           irq_id,
  output logic [LVL_W-1:0]           irq_ipl,
  output logic [NUM_SRC-1:0]         req_pend,
  output logic                       wdt_pend
);
  localparam logic [IDX_W-1:0] WDT_ID = IDX_W'(NUM_SRC);
  localparam logic [IDX_W-1:0] RST_ID = IDX_W'(NUM_SRC + 1);

  logic [NUM_SRC-1:0] req_eff, req_q, acc_clr, snap_req;
  lvl_t [NUM_SRC-1:0] lvl_now, snap_lvl;
  logic               snap_rst, snap_wdt, rst_q, wdt_q, busy;
  logic [CNT_W-1:0]   cnt;
  logic               win_vld;
  logic [IDX_W-1:0]   win_idx;
  lvl_t               win_lvl;

  // named internal events
  logic fetch_ok, decide, grant_rst, grant_wdt, grant_src;

  assign lvl_now  = src_lvl;
  assign fetch_ok = fetch & ~busy;
  assign decide   = busy & (cnt == '0);

  prio_arb_req #(.NUM_SRC(NUM_SRC), .NUM_EXT(NUM_EXT)) u_req (
    .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .ext_pin(ext_pin),
    .ext_pol(ext_pol), .ext_lvl(ext_lvl), .sw_clr(sw_clr),
    .acc_clr(acc_clr), .req_eff(req_eff), .req_q(req_q)
  );

  prio_arb_chain #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chain (
    .req(snap_req), .lvl(snap_lvl),
    .win_vld(win_vld), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  // fixed order: reset, then watchdog, then the chain winner
  assign grant_rst = decide & snap_rst;
  assign grant_wdt = decide & ~snap_rst & snap_wdt;
  assign grant_src = decide & ~snap_rst & ~snap_wdt & win_vld &
                     outranks(win_lvl, cpu_ipl) & ~cpu_idis;

  always_comb begin
    acc_clr = '0;
    if (grant_src) acc_clr[win_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      snap_req <= '0;
      snap_lvl <= '0;
      snap_rst <= 1'b0;
      snap_wdt <= 1'b0;
    end else if (fetch_ok) begin
      busy     <= 1'b1;
      cnt      <= wait_cycles(dly_sel) - CNT_W'(1);
      snap_req <= req_eff;
      snap_lvl <= lvl_now;
      snap_rst <= rst_q;
      snap_wdt <= wdt_q;
    end else if (decide) begin
      busy     <= 1'b0;
    end else if (busy) begin
      cnt      <= cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 1'b0;
      wdt_q <= 1'b0;
    end else begin
      rst_q <= rst_evt | (rst_q & ~grant_rst);
      wdt_q <= wdt_evt | (wdt_q & ~grant_wdt);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_take <= 1'b0;
      irq_id   <= '0;
      irq_ipl  <= '0;
    end else begin
      irq_take <= grant_rst | grant_wdt | grant_src;
      if (grant_rst) begin
        irq_id  <= RST_ID;
        irq_ipl <= LVL_AFTER_RST;
      end else if (grant_wdt) begin
        irq_id  <= WDT_ID;
        irq_ipl <= LVL_AFTER_WDT;
      end else if (grant_src) begin
        irq_id  <= win_idx;
        irq_ipl <= win_lvl;
      end
    end
  end

  assign req_pend = req_q;
  assign wdt_pend = wdt_q;

  assert_take_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> !irq_take);
  assert_src_above_ipl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && irq_id < WDT_ID) |-> (irq_ipl > $past(cpu_ipl) && !$past(cpu_idis)));
  assert_wdt_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && irq_id == WDT_ID) |-> (irq_ipl == LVL_AFTER_WDT));
  assert_rst_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && irq_id == RST_ID) |-> (irq_ipl == LVL_AFTER_RST));
  assert_wdt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_pend) |-> (irq_take && irq_id == WDT_ID));
endmodule

// File: tb/test_prio_arb.sv
module test_prio_arb;
  localparam int NS = 4;
  localparam int NE = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch = 1'b0;
  logic [1:0] dly_sel = 2'b00;
  logic [2:0] cpu_ipl = 3'd0;
  logic cpu_idis = 1'b0;
  logic [NS*3-1:0] src_lvl = '0;
  logic [NS-NE-1:0] hw_evt = '0;
  logic [NE-1:0] ext_pin = '0, ext_pol = '0, ext_lvl = '0;
  logic [NS-1:0] sw_clr = '0;
  logic rst_evt = 1'b0, wdt_evt = 1'b0;
  logic irq_take;
  logic [2:0] irq_id;
  logic [2:0] irq_ipl;
  logic [NS-1:0] req_pend;
  logic wdt_pend;

  int nchk = 0;
  int nbad = 0;

  always #10 clk = ~clk;

  prio_arb #(.NUM_SRC(NS), .NUM_EXT(NE)) i_prio_arb (
    .clk(clk), .rst_n(rst_n), .fetch(fetch), .dly_sel(dly_sel),
    .cpu_ipl(cpu_ipl), .cpu_idis(cpu_idis), .src_lvl(src_lvl),
    .hw_evt(hw_evt), .ext_pin(ext_pin), .ext_pol(ext_pol), .ext_lvl(ext_lvl),
    .sw_clr(sw_clr), .rst_evt(rst_evt), .wdt_evt(wdt_evt),
    .irq_take(irq_take), .irq_id(irq_id), .irq_ipl(irq_ipl),
    .req_pend(req_pend), .wdt_pend(wdt_pend)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clr_all();
    sw_clr = '1; step(); sw_clr = '0;
  endtask

  function automatic int delay_of(input logic [1:0] sel);
    if (sel == 2'b01) return 4;
    if (sel == 2'b10) return 2;
    return 7;
  endfunction

  // pulse fetch, then watch nine edges for the handshake
  task automatic run_fetch(input logic [1:0] sel, output bit seen, output int k,
                           output int id, output int ipl);
    fetch = 1'b1; dly_sel = sel; step(); fetch = 1'b0;
    seen = 0; k = 0; id = -1; ipl = -1;
    for (int j = 1; j <= 9; j++) begin
      step();
      if (!seen && irq_take) begin
        seen = 1; k = j; id = int'(irq_id); ipl = int'(irq_ipl);
      end
    end
  endtask

  // watchdog: a hung run is a failure and still reaches the summary
  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    bit seen;
    int k, id, ipl;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk(irq_take == 1'b0, "R1 irq_take", int'(irq_take), 0);
    chk(req_pend == '0, "R1 req_pend", int'(req_pend), 0);
    chk(wdt_pend == 1'b0, "R1 wdt_pend", int'(wdt_pend), 0);
    step(); step();

    // R2 polarity 0: rise ignored, fall sets
    ext_pin[0] = 1'b1; step();
    chk(req_pend[0] == 1'b0, "R2 rise pol0", int'(req_pend[0]), 0);
    ext_pin[0] = 1'b0; step();
    chk(req_pend[0] == 1'b1, "R2 fall pol0", int'(req_pend[0]), 1);
    // R2 polarity 1: rise sets, fall ignored (R4 clear same time)
    ext_pol[1] = 1'b1; step();
    ext_pin[1] = 1'b1; step();
    chk(req_pend[1] == 1'b1, "R2 rise pol1", int'(req_pend[1]), 1);
    ext_pin[1] = 1'b0; sw_clr[1] = 1'b1; step(); sw_clr = '0; step();
    chk(req_pend[1] == 1'b0, "R2 fall pol1 / R4 clear", int'(req_pend[1]), 0);
    ext_pol[1] = 1'b0;
    clr_all(); step();

    // R4 software clear versus simultaneous event (internal src2 = hw_evt[0])
    hw_evt[0] = 1'b1; step(); hw_evt = '0; step();
    chk(req_pend[2] == 1'b1, "R4 event sets", int'(req_pend[2]), 1);
    hw_evt[0] = 1'b1; sw_clr[2] = 1'b1; step(); hw_evt = '0; sw_clr = '0; step();
    chk(req_pend[2] == 1'b1, "R4 event beats clear", int'(req_pend[2]), 1);
    sw_clr[2] = 1'b1; step(); sw_clr = '0; step();
    chk(req_pend[2] == 1'b0, "R4 clear alone", int'(req_pend[2]), 0);

    // R3 stale stored bit ignored in level mode, then pin level requests
    src_lvl = {3'd0, 3'd0, 3'd0, 3'd5};
    ext_pin[0] = 1'b1; step(); ext_pin[0] = 1'b0; step();
    chk(req_pend[0] == 1'b1, "R3 stored bit set", int'(req_pend[0]), 1);
    ext_lvl[0] = 1'b1;
    run_fetch(2'b10, seen, k, id, ipl);
    chk(!seen, "R3 stored bit ignored", int'(seen), 0);
    ext_pol[0] = 1'b1;
    run_fetch(2'b01, seen, k, id, ipl);
    chk(seen && id == 0 && ipl == 5 && k == 4, "R3 low level pol1 grant", id, 0);
    ext_pol[0] = 1'b0; ext_pin[0] = 1'b1; step();
    run_fetch(2'b10, seen, k, id, ipl);
    chk(seen && id == 0 && ipl == 5 && k == 2, "R3 high level pol0 grant", id, 0);
    ext_lvl[0] = 1'b0; ext_pin[0] = 1'b0; step();
    clr_all(); step();

    // R5 tie goes to lower index; R7 only winner cleared
    src_lvl = {3'd6, 3'd6, 3'd0, 3'd0};
    hw_evt = 2'b11; step(); hw_evt = '0;
    run_fetch(2'b01, seen, k, id, ipl);
    chk(seen && id == 2 && ipl == 6, "R5 tie lower index", id, 2);
    chk(req_pend == 4'b1000, "R7 winner cleared", int'(req_pend), 8);
    clr_all(); step();

    // R8/R9 reset over watchdog, both past disable flag
    src_lvl = {3'd0, 3'd7, 3'd0, 3'd0};
    cpu_idis = 1'b1; cpu_ipl = 3'd3;
    hw_evt[0] = 1'b1; rst_evt = 1'b1; wdt_evt = 1'b1; step();
    hw_evt = '0; rst_evt = 1'b0; wdt_evt = 1'b0;
    run_fetch(2'b10, seen, k, id, ipl);
    chk(seen && id == NS + 1 && ipl == 0, "R8 reset first", id, NS + 1);
    chk(wdt_pend == 1'b1, "R9 watchdog kept", int'(wdt_pend), 1);
    run_fetch(2'b10, seen, k, id, ipl);
    chk(seen && id == NS && ipl == 7, "R8 watchdog second", id, NS);
    chk(wdt_pend == 1'b0, "R9 watchdog cleared on take", int'(wdt_pend), 0);
    run_fetch(2'b10, seen, k, id, ipl);
    chk(!seen, "R6 disable flag masks source", int'(seen), 0);
    chk(req_pend[2] == 1'b1, "R6 bits kept", int'(req_pend[2]), 1);
    wdt_evt = 1'b1; step(); wdt_evt = 1'b0; clr_all(); step();
    chk(wdt_pend == 1'b1, "R9 sw_clr no effect", int'(wdt_pend), 1);
    cpu_idis = 1'b0;
    run_fetch(2'b01, seen, k, id, ipl);
    chk(seen && id == NS && k == 4, "R8 watchdog taken", id, NS);

    // R10 late request and second fetch during wait ignored
    clr_all(); step();
    cpu_ipl = 3'd0;
    src_lvl = {3'd5, 3'd0, 3'd0, 3'd0};
    fetch = 1'b1; dly_sel = 2'b00; step(); fetch = 1'b0;
    seen = 0;
    hw_evt = 2'b10; step(); hw_evt = '0; seen |= irq_take;
    fetch = 1'b1; step(); fetch = 1'b0; seen |= irq_take;
    for (int j = 0; j < 9; j++) begin step(); seen |= irq_take; end
    chk(!seen, "R10 late request / busy fetch ignored", int'(seen), 0);
    run_fetch(2'b00, seen, k, id, ipl);
    chk(seen && id == 3 && k == 7, "R10 next fetch grants", k, 7);
    clr_all(); step();

    // exhaustive level sweep: R5 R6 R7 R10
    ext_lvl = 2'b11; ext_pol = 2'b00; ext_pin = 2'b11;
    for (int t = 0; t < 4096; t++) begin
      int m, widx, d;
      logic [1:0] sel;
      bit acc;
      src_lvl = t[11:0];
      cpu_ipl = 3'((t * 5) % 8);
      cpu_idis = ((t % 11) == 3);
      sel = 2'(t % 4);
      d = delay_of(sel);
      hw_evt = 2'b11; step(); hw_evt = '0;
      m = 0; widx = -1;
      for (int v = 7; v >= 1 && widx < 0; v--)
        for (int s = 0; s < NS && widx < 0; s++)
          if (int'(src_lvl[s*3 +: 3]) == v) begin m = v; widx = s; end
      acc = (widx >= 0) && (m > int'(cpu_ipl)) && !cpu_idis;
      run_fetch(sel, seen, k, id, ipl);
      if (acc)
        chk(seen && k == d && id == widx && ipl == m, "R5 R6 R7 R10 sweep grant",
            id * 100 + ipl * 10 + k, widx * 100 + m * 10 + d);
      else
        chk(!seen, "R6 sweep no grant", int'(seen), 0);
      clr_all();
    end

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule